// File: doc/BRIEF.md
# Pointer-Based Line Repair for Worn Memory Cells

This block keeps a 512-bit memory line usable after some of its cells have failed permanently. A small table of correction entries is stored next to the line. Each entry names one failed bit position with a 9-bit pointer and holds a single spare cell that stores the value that position should have. The read path takes the raw line as it comes out of the array. It replaces each bit that an entry points at with that entry's spare value and returns the repaired line in the same cycle.

On a write, the intended line is passed straight through to the array. The spare cell of every active entry also captures the intended value at its position. When a new failed position is found by some external check, it is reported on a management input. The block then claims the next unused entry for that position. If a spare cell in an older entry fails, the same position is reported again. The newer entry overrides the older one, so the table can repair faults in its own storage. A report that arrives when no entry is free sets a sticky flag. That flag marks the line as beyond repair.

Top module: `ecp_line_repair`

## Requirements
- R1: After reset all six entries are inactive, the beyond-repair flag is low, and the repaired line equals the raw line.
- R2: For every active entry, the repaired line bit at the entry's pointer equals the entry's spare value. Bits named by no active entry equal the raw line. The repaired line follows the raw line and the table in the same cycle, with no register in between.
- R3: When two or more active entries point at the same position, the entry with the highest index decides that bit.
- R4: A fault report while a free entry exists activates the lowest-index free entry at the next clock edge. That entry takes the reported position and the reported spare value. Active entries therefore always form a contiguous run starting at index 0.
- R5: On a write, at the next clock edge the spare value of each already active entry becomes the write-data bit at that entry's pointer. The write data appears unchanged on the raw write output in the same cycle. With no write and no fault report, the table does not change.
- R6: A fault report while all six entries are active sets the beyond-repair flag at the next edge and leaves every pointer and every active bit unchanged. The flag stays high until reset.
- R7: When a write and a fault report coincide, the newly activated entry holds the reported spare value. Entries that were already active take their values from the write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| raw_rd_i | input | 512 | Line as read from the array, faults included |
| corr_rd_o | output | 512 | Repaired line |
| wr_en_i | input | 1 | Write of the line in this cycle |
| wr_data_i | input | 512 | Intended line contents for the write |
| raw_wr_o | output | 512 | Data sent to the array for the write |
| flt_vld_i | input | 1 | A failed position is being reported |
| flt_pos_i | input | 9 | Reported failed bit position |
| flt_bit_i | input | 1 | Value the failed position should hold |
| ent_vld_o | output | 6 | Active flag per entry, bit i for entry i |
| ent_pos_o | output | 54 | Entry pointers, entry i in bits 9*i+8 down to 9*i |
| ent_bit_o | output | 6 | Spare value per entry, bit i for entry i |
| uncorr_o | output | 1 | Line has more failures than entries (sticky) |

## Verification
The bench reports the same position several times to exercise override order. A design that lets the lower index win would return the stale spare value. It also issues a report when the table is already full. A design that wraps its fill index there would silently overwrite entry 0 instead of raising the flag. Writes that coincide with a report check that the new entry keeps its reported value and is not overwritten by the write data. Pointers at bits 0 and 511 catch off-by-one slicing of the pointer field.

// File: rtl/ecp_pkg.sv
package ecp_pkg;
  localparam int unsigned DEF_LINE_W = 512;
  localparam int unsigned DEF_N_ENT  = 6;

  // what a fault report does to the table in a given cycle
  typedef enum logic [1:0] {
    RPT_NONE  = 2'd0,
    RPT_CLAIM = 2'd1,
    RPT_OVER  = 2'd2
  } rpt_act_e;
endpackage

// File: rtl/ecp_entry_store.sv
module ecp_entry_store
  import ecp_pkg::*;
#(
  parameter int unsigned LINE_W = DEF_LINE_W,
  parameter int unsigned N_ENT  = DEF_N_ENT,
  parameter int unsigned POS_W  = $clog2(LINE_W),
  parameter int unsigned CNT_W  = $clog2(N_ENT + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [LINE_W-1:0]      wr_data,
  input  logic                   flt_vld,
  input  logic [POS_W-1:0]       flt_pos,
  input  logic                   flt_bit,
  output logic [N_ENT-1:0]       vld,
  output logic [N_ENT*POS_W-1:0] pos,
  output logic [N_ENT-1:0]       spare,
  output logic                   full,
  output logic                   claim_fire,
  output logic                   over_fire,
  output logic                   uncorr
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(N_ENT);

  logic [CNT_W-1:0] fill_cnt;
  rpt_act_e         act;

  assign full = (fill_cnt == FULL_CNT);

  always_comb begin
    act = RPT_NONE;
    if (flt_vld) act = full ? RPT_OVER : RPT_CLAIM;
  end

  assign claim_fire = (act == RPT_CLAIM);
  assign over_fire  = (act == RPT_OVER);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill_cnt <= '0;
      uncorr   <= 1'b0;
    end else begin
      if (claim_fire) fill_cnt <= fill_cnt + 1'b1;
      if (over_fire)  uncorr   <= 1'b1;
    end
  end

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    logic [POS_W-1:0] ptr_q;
    logic             take_new;
    assign take_new = claim_fire && (fill_cnt == CNT_W'(g));
    assign pos[g*POS_W +: POS_W] = ptr_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld[g]   <= 1'b0;
        ptr_q    <= '0;
        spare[g] <= 1'b0;
      end else if (take_new) begin
        vld[g]   <= 1'b1;
        ptr_q    <= flt_pos;
        spare[g] <= flt_bit;
      end else if (wr_en && vld[g]) begin
        spare[g] <= wr_data[ptr_q];
      end
    end
  end
endmodule

// File: rtl/ecp_overlay.sv
module ecp_overlay
  import ecp_pkg::*;
#(
  parameter int unsigned LINE_W = DEF_LINE_W,
  parameter int unsigned N_ENT  = DEF_N_ENT,
  parameter int unsigned POS_W  = $clog2(LINE_W)
) (
  input  logic [LINE_W-1:0]      raw,
  input  logic [N_ENT-1:0]       vld,
  input  logic [N_ENT*POS_W-1:0] pos,
  input  logic [N_ENT-1:0]       spare,
  output logic [LINE_W-1:0]      corr
);
  // entries applied in rising index order: a later write wins
  function automatic logic [LINE_W-1:0] patch_line(
    input logic [LINE_W-1:0]      r,
    input logic [N_ENT-1:0]       v,
    input logic [N_ENT*POS_W-1:0] p,
    input logic [N_ENT-1:0]       s
  );
    logic [LINE_W-1:0] acc;
    acc = r;
    for (int i = 0; i < N_ENT; i++) begin
      if (v[i]) acc[p[i*POS_W +: POS_W]] = s[i];
    end
    return acc;
  endfunction

  always_comb corr = patch_line(raw, vld, pos, spare);
endmodule

// File: rtl/ecp_line_repair.sv
module ecp_line_repair
  import ecp_pkg::*;
#(
  parameter int unsigned LINE_W = DEF_LINE_W,
  parameter int unsigned N_ENT  = DEF_N_ENT,
  parameter int unsigned POS_W  = $clog2(LINE_W)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [LINE_W-1:0]      raw_rd_i,
  output logic [LINE_W-1:0]      corr_rd_o,
  input  logic                   wr_en_i,
  input  logic [LINE_W-1:0]      wr_data_i,
  output logic [LINE_W-1:0]      raw_wr_o,
  input  logic                   flt_vld_i,
  input  logic [POS_W-1:0]       flt_pos_i,
  input  logic                   flt_bit_i,
  output logic [N_ENT-1:0]       ent_vld_o,
  output logic [N_ENT*POS_W-1:0] ent_pos_o,
  output logic [N_ENT-1:0]       ent_bit_o,
  output logic                   uncorr_o
);
  logic full_w;
  logic claim_w;
  logic over_w;

  ecp_entry_store #(.LINE_W(LINE_W), .N_ENT(N_ENT), .POS_W(POS_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en_i),
    .wr_data    (wr_data_i),
    .flt_vld    (flt_vld_i),
    .flt_pos    (flt_pos_i),
    .flt_bit    (flt_bit_i),
    .vld        (ent_vld_o),
    .pos        (ent_pos_o),
    .spare      (ent_bit_o),
    .full       (full_w),
    .claim_fire (claim_w),
    .over_fire  (over_w),
    .uncorr     (uncorr_o)
  );

  ecp_overlay #(.LINE_W(LINE_W), .N_ENT(N_ENT), .POS_W(POS_W)) u_ovl (
    .raw   (raw_rd_i),
    .vld   (ent_vld_o),
    .pos   (ent_pos_o),
    .spare (ent_bit_o),
    .corr  (corr_rd_o)
  );

  assign raw_wr_o = wr_data_i;
endmodule

// File: rtl/ecp_line_repair_chk.sv
module ecp_line_repair_chk #(
  parameter int unsigned LINE_W = 512,
  parameter int unsigned N_ENT  = 6,
  parameter int unsigned POS_W  = $clog2(LINE_W)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [LINE_W-1:0]      raw,
  input logic [LINE_W-1:0]      corr,
  input logic                   wr_en,
  input logic                   flt_vld,
  input logic [N_ENT-1:0]       ent_vld,
  input logic [N_ENT*POS_W-1:0] ent_pos,
  input logic [N_ENT-1:0]       ent_bit,
  input logic                   uncorr,
  input logic                   full,
  input logic                   claim_fire,
  input logic                   over_fire
);
  AST_VLD_CONTIG: assert property (@(posedge clk) disable iff (!rst_n)
    ((ent_vld & (ent_vld + 1'b1)) == '0)); // R4
  AST_CLAIM_GROW: assert property (@(posedge clk) disable iff (!rst_n)
    claim_fire |=> ($countones(ent_vld) == $countones($past(ent_vld)) + 1)); // R4
  AST_FULL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_vld && full && !wr_en) |=> ($stable(ent_vld) && $stable(ent_pos) && $stable(ent_bit))); // R6
  AST_OVER_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    over_fire |=> uncorr); // R6
  AST_UNCORR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    uncorr |=> uncorr); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!flt_vld && !wr_en) |=> ($stable(ent_vld) && $stable(ent_pos) && $stable(ent_bit))); // R5
  AST_EMPTY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_vld == '0) |-> (corr == raw)); // R1
endmodule

bind ecp_line_repair ecp_line_repair_chk #(.LINE_W(LINE_W), .N_ENT(N_ENT), .POS_W(POS_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .raw        (raw_rd_i),
  .corr       (corr_rd_o),
  .wr_en      (wr_en_i),
  .flt_vld    (flt_vld_i),
  .ent_vld    (ent_vld_o),
  .ent_pos    (ent_pos_o),
  .ent_bit    (ent_bit_o),
  .uncorr     (uncorr_o),
  .full       (full_w),
  .claim_fire (claim_w),
  .over_fire  (over_w)
);

// File: tb/ecp_line_repair_bench.sv
`timescale 1ns/1ps
module ecp_line_repair_bench;
  localparam int LW = 512;
  localparam int NE = 6;
  localparam int PW = 9;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [LW-1:0] raw_rd = '0;
  logic [LW-1:0] corr_rd;
  logic          wr_en = 1'b0;
  logic [LW-1:0] wr_data = '0;
  logic [LW-1:0] raw_wr;
  logic          flt_vld = 1'b0;
  logic [PW-1:0] flt_pos = '0;
  logic          flt_bit = 1'b0;
  logic [NE-1:0] ent_vld;
  logic [NE*PW-1:0] ent_pos;
  logic [NE-1:0] ent_bit;
  logic          uncorr;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  // reference table
  bit          m_vld [NE];
  logic [PW-1:0] m_pos [NE];
  bit          m_bit [NE];
  int          m_cnt;
  bit          m_unc;

  always #5 clk = ~clk;

  ecp_line_repair u_ecp_line_repair (
    .clk(clk), .rst_n(rst_n), .raw_rd_i(raw_rd), .corr_rd_o(corr_rd),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .raw_wr_o(raw_wr),
    .flt_vld_i(flt_vld), .flt_pos_i(flt_pos), .flt_bit_i(flt_bit),
    .ent_vld_o(ent_vld), .ent_pos_o(ent_pos), .ent_bit_o(ent_bit),
    .uncorr_o(uncorr)
  );

  function automatic logic [LW-1:0] rand_line();
    logic [LW-1:0] v;
    for (int k = 0; k < LW/32; k++) v[k*32 +: 32] = $urandom();
    return v;
  endfunction

  // highest index scanned first; first hit per position is final
  function automatic logic [LW-1:0] exp_line(input logic [LW-1:0] r);
    logic [LW-1:0] v;
    logic [LW-1:0] taken;
    v = r;
    taken = '0;
    for (int i = NE - 1; i >= 0; i--) begin
      if (m_vld[i] && !taken[m_pos[i]]) begin
        v[m_pos[i]] = m_bit[i];
        taken[m_pos[i]] = 1'b1;
      end
    end
    return v;
  endfunction

  task automatic chk(input string req, input string what, input logic [LW-1:0] act, input logic [LW-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic chk_table(input string req);
    logic [NE-1:0] ev;
    logic [NE*PW-1:0] ep;
    logic [NE-1:0] eb;
    for (int i = 0; i < NE; i++) begin
      ev[i] = m_vld[i];
      ep[i*PW +: PW] = m_vld[i] ? m_pos[i] : '0;
      eb[i] = m_vld[i] ? m_bit[i] : 1'b0;
    end
    chk(req, "ent_vld", LW'(ent_vld), LW'(ev));
    chk(req, "ent_pos", LW'(ent_pos), LW'(ep));
    chk(req, "ent_bit", LW'(ent_bit), LW'(eb));
    chk(req, "uncorr", LW'(uncorr), LW'(m_unc));
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_en = 0; flt_vld = 0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NE; i++) begin m_vld[i] = 0; m_pos[i] = '0; m_bit[i] = 0; end
    m_cnt = 0; m_unc = 0;
    raw_rd = rand_line();
    #1;
    chk_table("R1");
    chk("R1", "corr after reset", corr_rd, raw_rd);
  endtask

  // called at a negedge; applies one cycle of stimulus
  task automatic cycle(input logic [LW-1:0] raw, input bit we, input logic [LW-1:0] wd,
                       input bit fv, input logic [PW-1:0] fp, input bit fb, input string req);
    logic [LW-1:0] wd_old;
    raw_rd = raw; wr_en = we; wr_data = wd; flt_vld = fv; flt_pos = fp; flt_bit = fb;
    #1;
    chk("R2", {req, " corr"}, corr_rd, exp_line(raw));
    if (we) chk("R5", "raw_wr", raw_wr, wd);
    wd_old = wd;
    @(posedge clk);
    if (we) for (int i = 0; i < NE; i++) if (m_vld[i]) m_bit[i] = wd_old[m_pos[i]];
    if (fv) begin
      if (m_cnt == NE) m_unc = 1;
      else begin
        m_vld[m_cnt] = 1; m_pos[m_cnt] = fp; m_bit[m_cnt] = fb; m_cnt++;
      end
    end
    @(negedge clk);
    wr_en = 0; flt_vld = 0;
    #1;
    chk_table(req);
    chk(req, "corr next", corr_rd, exp_line(raw_rd));
  endtask

  initial begin
    logic [LW-1:0] z;
    void'($urandom(32'h0ECC_5EED));
    z = '0;
    @(negedge clk);
    do_reset();

    // R2/R4: claim entry 0 at pos 5 value 1 over raw zeros
    cycle(z, 0, z, 1, 9'd5, 1'b1, "R4");
    chk("R2", "bit5 forced", LW'(corr_rd[5]), LW'(1'b1));
    // R3: same position again, newer entry wins
    cycle(z, 0, z, 1, 9'd5, 1'b0, "R3");
    chk("R3", "bit5 newer", LW'(corr_rd[5]), LW'(1'b0));
    // boundaries 0 and 511
    cycle(z, 0, z, 1, 9'd0, 1'b1, "R4");
    cycle(~z, 0, z, 1, 9'd511, 1'b0, "R4");
    chk("R2", "bit511", LW'(corr_rd[511]), LW'(1'b0));
    // R5: write refreshes spares
    cycle(z, 1, ~z, 0, '0, 0, "R5");
    cycle(z, 0, z, 0, '0, 0, "R5");
    // R7: write with claim
    cycle(z, 1, z, 1, 9'd300, 1'b1, "R7");
    cycle(z, 0, z, 1, 9'd301, 1'b1, "R4");
    // R6: table full now, extra report
    cycle(z, 0, z, 1, 9'd7, 1'b1, "R6");
    chk("R6", "uncorr set", LW'(uncorr), LW'(1'b1));
    cycle(z, 0, z, 0, '0, 0, "R6");
    cycle(z, 1, ~z, 1, 9'd9, 1'b0, "R6");

    for (int s = 0; s < 40; s++) begin
      do_reset();
      for (int c = 0; c < 12; c++) begin
        bit fv, we, fb;
        logic [PW-1:0] fp;
        fv = ($urandom() % 2) == 0;
        we = ($urandom() % 3) == 0;
        fb = $urandom();
        if (m_cnt > 0 && ($urandom() % 3) == 0) fp = m_pos[$urandom() % m_cnt];
        else fp = PW'($urandom());
        cycle(rand_line(), we, rand_line(), fv, fp, fb, (we && fv) ? "R7" : (fv ? "R4" : "R5"));
      end
    end

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    #1_500_000;
    if (!done) begin
      done = 1;
      compared++; mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule